// File: doc/BRIEF.md
# DDR Command Timing Guard

This block sits between a DDR command scheduler and the memory command bus. Each cycle the scheduler offers one command: activate, read, precharge, precharge-all, or a generic command. The guard answers with a combinational ready. A command is granted in a cycle where it is both valid and ready. The guard holds back any command that would break one of several programmed minimum spacings. It also listens for a CKE rising event from the power-down logic, together with a flag that says whether the exit was slow or fast.

All spacings come from one 32-bit register, which software reaches through a plain write/read port. The spacings are:
- a sliding window that allows at most four activates;
- a minimum gap from read to precharge;
- a settle time after a precharge-all, during which no command may pass;
- a power-down-exit-to-read gap, whose length depends on the exit mode.

Each spacing is measured by a saturating cycle counter that starts on the triggering event. The counter is compared against the live register field. A register write therefore changes later decisions without restarting any count.

Top module: `ddr_cmd_timing_guard`

## Requirements
- R1: The timing register sits at address 0x14 and reads 0x00042062 after reset. A read at any other address returns zero, and a write to any other address leaves the register unchanged.
- R2: Bits 31:20 and bit 15 always read zero and ignore writes. A write to address 0x14 stores all the other bits, and the stored value is visible in the next cycle.
- R3: Bits 19:16 give the activate window W. An activate (cmd_kind 0) is not ready while the fourth most recent granted activate lies fewer than W cycles in the past.
- R4: Bits 14:12 give the read-to-precharge gap. A precharge (cmd_kind 2) or precharge-all (cmd_kind 3) is not ready until that many cycles have passed since the last granted read (cmd_kind 1).
- R5: Bits 11:8 give the precharge-all settle time. No command of any kind is ready until that many cycles have passed since the last granted precharge-all.
- R6: Bits 7:4 (slow exit) and bits 3:0 (fast exit) give the power-down exit gap. A read is not ready until the selected gap has passed since the last cke_rise. The gap is bits 7:4 when cke_slow_exit was 1 at that event and bits 3:0 when it was 0. Commands other than reads are not affected.
- R7: A field programmed to 0 or 1 never stalls the command that follows its event. A command that is N cycles after its event is allowed once N is at least the field value.
- R8: cmd_ready depends only on cmd_kind and the guard state. A grant is cmd_valid AND cmd_ready. Commands that are offered but not granted start no timer. Kind codes 4 to 7 are generic commands and are gated only by R5. After reset every kind is ready.
- R9: A register write takes effect on the comparisons in the following cycles. It does not restart any spacing already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| cmd_valid | input | 1 | Scheduler offers a command this cycle |
| cmd_kind | input | 3 | 0 activate, 1 read, 2 precharge, 3 precharge-all, 4-7 generic |
| cmd_ready | output | 1 | The offered kind may be issued this cycle |
| cke_rise | input | 1 | CKE went high (power-down exit) this cycle |
| cke_slow_exit | input | 1 | Mode of the exit signalled by cke_rise: 1 slow, 0 fast |

## Verification
The bench offers back-to-back activates under an eight-cycle window. This shows whether the fifth activate is held for exactly the right number of cycles, and not for one cycle too few or too many. An all-zero register with dense mixed traffic exposes any off-by-one in the zero/one boundary. A read followed by a change to the read-to-precharge field, written while that spacing is still running, separates live comparison from latched or restarted counts. Long random traffic with random register writes, exit events in both modes, and undecoded kind codes is checked every cycle against an event-time model. That model catches a rule applied to the wrong kind, the wrong exit field being selected, or a timer started by a command that was offered but not granted.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    localparam int CNT_W     = 4;
    localparam int ACT_LIMIT = 4;

    localparam logic [7:0]  TIMING_OFFSET = 8'h14;
    localparam logic [31:0] TIMING_RESET  = 32'h0004_2062;
    localparam logic [31:0] TIMING_WMASK  = 32'h000F_7FFF;

    typedef logic [CNT_W-1:0] age_t;
    localparam age_t AGE_MAX = {CNT_W{1'b1}};

    typedef enum logic [2:0] {
        CMD_ACT   = 3'd0,
        CMD_RD    = 3'd1,
        CMD_PRE   = 3'd2,
        CMD_PREA  = 3'd3,
        CMD_OTHER = 3'd4
    } cmd_kind_e;

    typedef struct packed {
        logic [11:0] spare_hi;
        logic [3:0]  act_window;
        logic        spare15;
        logic [2:0]  rd_to_pre;
        logic [3:0]  pre_all;
        logic [3:0]  exit_slow;
        logic [3:0]  exit_fast;
    } timing_cfg_t;

    function automatic age_t age_inc(input age_t a);
        return (a == AGE_MAX) ? a : a + age_t'(1);
    endfunction

    function automatic logic gap_met(input age_t age, input logic [3:0] need);
        return age >= age_t'(need);
    endfunction

endpackage

// File: rtl/dtg_cfg_regs.sv
module dtg_cfg_regs
    import dtg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output timing_cfg_t       cfg
);

    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(TIMING_OFFSET);

    logic [31:0] store_q;
    logic        hit;

    assign hit = (addr == MY_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= TIMING_RESET;
        end else if (wr_en && hit) begin
            store_q <= wdata & TIMING_WMASK;
        end
    end

    assign rdata = hit ? store_q : 32'd0;
    assign cfg   = timing_cfg_t'(store_q);

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit) |=> (store_q == ($past(wdata) & TIMING_WMASK)));

    assert_foreign_write_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hit) |=> (store_q == $past(store_q)));

endmodule

// File: rtl/dtg_since.sv
module dtg_since
    import dtg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    output age_t age
);

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= AGE_MAX;
        end else if (start) begin
            age <= age_t'(1);
        end else begin
            age <= age_inc(age);
        end
    end

    assert_age_monotone_R8: assert property (@(posedge clk) disable iff (rst)
        !start |=> (age >= $past(age)));

    assert_age_restart_R8: assert property (@(posedge clk) disable iff (rst)
        start |=> (age == age_t'(1)));

endmodule

// File: rtl/dtg_act_window.sv
module dtg_act_window
    import dtg_pkg::*;
#(
    parameter int DEPTH = ACT_LIMIT
) (
    input  logic clk,
    input  logic rst,
    input  logic act_grant,
    output age_t oldest
);

    age_t ages [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                ages[i] <= AGE_MAX;
            end
        end else if (act_grant) begin
            ages[0] <= age_t'(1);
            for (int i = 1; i < DEPTH; i++) begin
                ages[i] <= age_inc(ages[i-1]);
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                ages[i] <= age_inc(ages[i]);
            end
        end
    end

    assign oldest = ages[DEPTH-1];

    generate
        for (genvar g = 0; g + 1 < DEPTH; g++) begin : g_order
            assert_age_order_R3: assert property (@(posedge clk) disable iff (rst)
                ages[g] <= ages[g+1]);
        end
    endgenerate

endmodule

// File: rtl/ddr_cmd_timing_guard.sv
module ddr_cmd_timing_guard
    import dtg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_kind,
    output logic              cmd_ready,
    input  logic              cke_rise,
    input  logic              cke_slow_exit
);

    timing_cfg_t cfg;
    age_t        since_rd, since_prea, since_cke, act_oldest;
    logic        exit_slow_q;
    logic        granted;
    logic [3:0]  exit_need;
    logic        ok_prea, ok_rtp, ok_exit, ok_faw;

    dtg_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr_en),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    assign granted = cmd_valid && cmd_ready;

    dtg_since u_rd (
        .clk(clk), .rst(rst),
        .start(granted && cmd_kind == CMD_RD),
        .age(since_rd)
    );

    dtg_since u_prea (
        .clk(clk), .rst(rst),
        .start(granted && cmd_kind == CMD_PREA),
        .age(since_prea)
    );

    dtg_since u_cke (
        .clk(clk), .rst(rst),
        .start(cke_rise),
        .age(since_cke)
    );

    dtg_act_window #(.DEPTH(ACT_LIMIT)) u_faw (
        .clk(clk), .rst(rst),
        .act_grant(granted && cmd_kind == CMD_ACT),
        .oldest(act_oldest)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            exit_slow_q <= 1'b0;
        end else if (cke_rise) begin
            exit_slow_q <= cke_slow_exit;
        end
    end

    assign exit_need = exit_slow_q ? cfg.exit_slow : cfg.exit_fast;

    assign ok_prea = gap_met(since_prea, cfg.pre_all);
    assign ok_rtp  = gap_met(since_rd, {1'b0, cfg.rd_to_pre});
    assign ok_exit = gap_met(since_cke, exit_need);
    assign ok_faw  = gap_met(act_oldest, cfg.act_window);

    always_comb begin
        cmd_ready = ok_prea;
        case (cmd_kind)
            CMD_ACT:           cmd_ready = ok_prea && ok_faw;
            CMD_RD:            cmd_ready = ok_prea && ok_exit;
            CMD_PRE, CMD_PREA: cmd_ready = ok_prea && ok_rtp;
            default:           cmd_ready = ok_prea;
        endcase
    end

    assert_prea_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        (granted && cmd_kind == CMD_PREA && cfg.pre_all > 4'd1 && !reg_wr_en)
        |=> !cmd_ready);

    assert_rd_blocks_pre_R4: assert property (@(posedge clk) disable iff (rst)
        (granted && cmd_kind == CMD_RD && cfg.rd_to_pre > 3'd1 && !reg_wr_en)
        |=> (!cmd_ready || !(cmd_kind == CMD_PRE || cmd_kind == CMD_PREA)));

    assert_exit_blocks_rd_R6: assert property (@(posedge clk) disable iff (rst)
        (cke_rise && !reg_wr_en &&
         ((cke_slow_exit ? cfg.exit_slow : cfg.exit_fast) > 4'd1))
        |=> (!cmd_ready || cmd_kind != CMD_RD));

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[31:20] == 12'd0) && !reg_rdata[15]);

endmodule

// File: tb/sim_ddr_cmd_timing_guard.sv
module sim_ddr_cmd_timing_guard;

    localparam int MASK  = 32'h000F7FFF;
    localparam int NEVER = -1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h14;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_kind = '0;
    logic        cmd_ready;
    logic        cke_rise = 1'b0;
    logic        cke_slow_exit = 1'b0;

    int checks = 0;
    int fails  = 0;

    int          cyc;
    logic [31:0] m_reg;
    int          t_rd, t_prea, t_cke;
    logic        m_slow;
    int          acts [4];

    always #4 clk = ~clk;

    ddr_cmd_timing_guard u0 (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_ready(cmd_ready),
        .cke_rise(cke_rise), .cke_slow_exit(cke_slow_exit)
    );

    function automatic bit exp_ready(input int kind);
        bit ok;
        int xneed;
        ok = (cyc - t_prea) >= int'(m_reg[11:8]);
        xneed = m_slow ? int'(m_reg[7:4]) : int'(m_reg[3:0]);
        case (kind)
            0: ok = ok && ((cyc - acts[3]) >= int'(m_reg[19:16]));
            1: ok = ok && ((cyc - t_cke) >= xneed);
            2, 3: ok = ok && ((cyc - t_rd) >= int'(m_reg[14:12]));
            default: ;
        endcase
        return ok;
    endfunction

    function automatic string kind_tag(input int kind);
        case (kind)
            0: return "R3";
            1: return "R6";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        cyc = 0;
        m_reg = 32'h00042062;
        t_rd = NEVER; t_prea = NEVER; t_cke = NEVER;
        m_slow = 1'b0;
        for (int i = 0; i < 4; i++) acts[i] = NEVER;
    endtask

    task automatic step(input bit v, input int kind, input bit cke, input bit slow,
                        input bit wr, input logic [7:0] addr, input logic [31:0] wd,
                        input string tag, output bit got);
        bit e;
        @(negedge clk);
        cmd_valid = v; cmd_kind = 3'(kind); cke_rise = cke; cke_slow_exit = slow;
        reg_wr_en = wr; reg_addr = addr; reg_wdata = wd;
        #2;
        e = exp_ready(kind);
        got = cmd_ready;
        check((tag == "") ? kind_tag(kind) : tag, 32'(cmd_ready), 32'(e));
        @(posedge clk);
        if (v && e) begin
            if (kind == 0) begin
                for (int i = 3; i > 0; i--) acts[i] = acts[i-1];
                acts[0] = cyc;
            end
            if (kind == 1) t_rd = cyc;
            if (kind == 3) t_prea = cyc;
        end
        if (cke) begin t_cke = cyc; m_slow = slow; end
        if (wr && addr == 8'h14) m_reg = wd & MASK;
        cyc++;
    endtask

    task automatic idle(input string tag);
        bit g;
        step(0, 4, 0, 0, 0, 8'h14, 0, tag, g);
    endtask

    task automatic wr_reg(input logic [7:0] addr, input logic [31:0] d);
        bit g;
        step(0, 4, 0, 0, 1, addr, d, "R5", g);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit g;
        int stall_at, resume_at;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset value and decode
        reg_addr = 8'h14; #1;
        check("R1", reg_rdata, 32'h00042062);
        reg_addr = 8'h10; #1;
        check("R1", reg_rdata, 32'h0);
        // R8 all kinds ready after reset
        for (int k = 0; k < 8; k++) begin
            cmd_kind = 3'(k); #1;
            check("R8", 32'(cmd_ready), 32'd1);
        end

        // R2 write mask; R1 foreign address write ignored
        wr_reg(8'h14, 32'hFFFF_FFFF);
        @(negedge clk); reg_wr_en = 0; reg_addr = 8'h14; #1;
        check("R2", reg_rdata, 32'h000F7FFF);
        wr_reg(8'h18, 32'h0);
        @(negedge clk); reg_wr_en = 0; reg_addr = 8'h14; #1;
        check("R1", reg_rdata, 32'h000F7FFF);
        wr_reg(8'h14, 32'h1234_ABCD);
        @(negedge clk); reg_wr_en = 0; reg_addr = 8'h14; #1;
        check("R2", reg_rdata, 32'h1234_ABCD & MASK);

        // R3 directed: window 8, back-to-back activates
        wr_reg(8'h14, 32'h0008_0000);
        repeat (16) idle("R3");
        stall_at = -1; resume_at = -1;
        for (int i = 0; i < 12; i++) begin
            step(1, 0, 0, 0, 0, 8'h14, 0, "R3", g);
            if (!g && stall_at < 0) stall_at = i;
            if (g && stall_at >= 0 && resume_at < 0) resume_at = i;
        end
        check("R3", 32'(stall_at), 32'd4);
        check("R3", 32'(resume_at), 32'd8);

        // R7 all-zero fields never stall
        wr_reg(8'h14, 32'h0);
        repeat (16) idle("R7");
        step(1, 3, 0, 0, 0, 8'h14, 0, "R7", g); check("R7", 32'(g), 1);
        step(1, 1, 1, 1, 0, 8'h14, 0, "R7", g); check("R7", 32'(g), 1);
        step(1, 1, 0, 0, 0, 8'h14, 0, "R7", g); check("R7", 32'(g), 1);
        step(1, 2, 0, 0, 0, 8'h14, 0, "R7", g); check("R7", 32'(g), 1);
        for (int i = 0; i < 6; i++) begin
            step(1, 0, 0, 0, 0, 8'h14, 0, "R7", g); check("R7", 32'(g), 1);
        end

        // R9 write while read-to-precharge spacing is running
        wr_reg(8'h14, 32'h0000_7000);
        step(1, 1, 0, 0, 0, 8'h14, 0, "R9", g);
        idle("R9"); idle("R9");
        step(1, 2, 0, 0, 1, 8'h14, 32'h0000_2000, "R9", g);
        check("R9", 32'(g), 0);
        step(1, 2, 0, 0, 0, 8'h14, 0, "R9", g);
        check("R9", 32'(g), 1);

        // R6 directed: slow exit 6 vs fast 2 (reset value)
        wr_reg(8'h14, 32'h00042062);
        repeat (16) idle("R6");
        step(0, 1, 1, 1, 0, 8'h14, 0, "R6", g);
        for (int i = 1; i < 8; i++) begin
            step(0, 1, 0, 0, 0, 8'h14, 0, "R6", g);
            check("R6", 32'(g), 32'(i >= 6));
        end

        // Random traffic against the model (all requirements)
        for (int n = 0; n < 4000; n++) begin
            bit v, ck, sl, w;
            int k;
            logic [7:0] a;
            logic [31:0] d;
            v  = ($urandom % 10) < 7;
            k  = $urandom % 8;
            ck = ($urandom % 20) == 0;
            sl = $urandom % 2;
            w  = ($urandom % 50) == 0;
            a  = (($urandom % 4) == 0) ? 8'h20 : 8'h14;
            d  = $urandom;
            step(v, k, ck, sl, w, a, d, "", g);
        end

        @(negedge clk); reg_wr_en = 0; reg_addr = 8'h14; #1;
        check("R2", reg_rdata, m_reg);
        finish_run();
    end

endmodule